// File: doc/BRIEF.md
# Bit-Sliced Microoperation Register

This block is an n-bit register whose contents are changed each clock by one of three operations chosen by external control lines: a left shift by one place, a bitwise XOR with an input word, or a modular addition of that input word. When no control line is high, the register keeps its value. The register is built as a row of identical one-bit slices. Each slice holds a small piece of combinational logic in front of one flip-flop. A single control decoder, shared by all slices, drives every slice.

All three operations run through one chain between neighbouring slices. During an addition, the chain carries the ripple carry. During a shift, each slice passes its own stored bit up the same chain, and the slice above takes that incoming bit as its next value. During an XOR, the chain is held at zero, so the adder's sum output becomes the XOR of the register and the input. The control lines should be one-hot. If more than one is high, a fixed priority picks the operation.

Top module: `microop_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, `a_out` is all zeros after that edge, whatever the control inputs are.
- R2: When `do_shift`, `do_xor` and `do_add` are all low at an edge, `a_out` keeps its value across that edge, whatever `b_in` is.
- R3: When `do_shift` is high at an edge, bit i of `a_out` takes the old bit i-1 for i from 1 to W-1. Bit 0 becomes 0, and the old top bit is dropped.
- R4: When `do_add` is high and `do_shift` is low at an edge, `a_out` becomes (old `a_out` + `b_in`) modulo 2^W. The carry into bit 0 is 0, and the carry out of bit W-1 is discarded.
- R5: When `do_xor` is the only control line high at an edge, `a_out` becomes old `a_out` XOR `b_in`. No carry moves between bits.
- R6: When more than one control line is high, shift takes priority over add, and add takes priority over XOR.
- R7: Every operation takes effect at the first rising edge after its control line is sampled high, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| b_in | input | W | Operand word for XOR and add |
| do_shift | input | 1 | Select a left shift by one place |
| do_xor | input | 1 | Select a bitwise XOR with `b_in` |
| do_add | input | 1 | Select the addition of `b_in` |
| a_out | output | W | Current register contents |

## Verification
The bench adds all-ones to one, and all-ones to all-ones, to drive a carry through every slice and out of the top. A carry chain that is broken or cut short leaves ones behind, and a top carry that is not discarded wraps a stray bit into the result. It shifts values that have the top bit set and values that have bit 0 set. A design that fills the vacated bit from the chain's leftover state, or that rotates instead of shifting, gives a wrong low or high bit. It also applies XOR with operands that would carry in an adder, applies several control lines at once, and changes `b_in` while holding. A chain that is not forced to zero during XOR, an inverted priority, or a hold that lets `b_in` leak through each show up as a mismatch against the bench's model.

// File: rtl/microop_pkg.sv
package microop_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_ADD   = 2'd2,
        OP_XOR   = 2'd3
    } op_e;

    // Control word shared by every slice of the register.
    typedef struct packed {
        logic load;      // flip-flop captures a new value
        logic pick_ci;   // next value is the incoming chain bit (shift)
        logic carry_en;  // chain carries an arithmetic carry (add)
    } slice_ctl_t;

    // Fixed priority when the one-hot rule is broken: shift, add, xor.
    function automatic op_e pick_op(logic sh, logic xr, logic ad);
        op_e op;
        if (sh)      op = OP_SHIFT;
        else if (ad) op = OP_ADD;
        else if (xr) op = OP_XOR;
        else         op = OP_HOLD;
        return op;
    endfunction

    function automatic slice_ctl_t ctl_of(op_e op);
        slice_ctl_t c;
        c = '0;
        unique case (op)
            OP_SHIFT: begin c.load = 1'b1; c.pick_ci = 1'b1; end
            OP_ADD:   begin c.load = 1'b1; c.carry_en = 1'b1; end
            OP_XOR:   begin c.load = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/op_decoder.sv
module op_decoder
    import microop_pkg::*;
(
    input  logic       do_shift,
    input  logic       do_xor,
    input  logic       do_add,
    output slice_ctl_t ctl
);
    op_e op;

    always_comb begin
        op  = pick_op(do_shift, do_xor, do_add);
        ctl = ctl_of(op);
    end
endmodule

// File: rtl/carry_link.sv
module carry_link (
    input  logic a_bit,
    input  logic b_bit,
    input  logic ci,
    input  logic pick_ci,
    input  logic carry_en,
    output logic co
);
    // Shift: pass own bit upward. Add: majority carry. Xor/hold: zero.
    always_comb begin
        if (pick_ci)       co = a_bit;
        else if (carry_en) co = (a_bit & b_bit) | (ci & (a_bit ^ b_bit));
        else               co = 1'b0;
    end
endmodule

// File: rtl/slice_cell.sv
module slice_cell (
    input  logic clk,
    input  logic rst,
    input  logic b_bit,
    input  logic ci,
    input  logic load,
    input  logic pick_ci,
    output logic a_bit
);
    logic sum;
    logic nxt;

    always_comb begin
        sum = a_bit ^ b_bit ^ ci;
        nxt = pick_ci ? ci : sum;
    end

    always_ff @(posedge clk) begin
        if (rst)       a_bit <= 1'b0;
        else if (load) a_bit <= nxt;
    end
endmodule

// File: rtl/microop_reg.sv
module microop_reg
    import microop_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] b_in,
    input  logic         do_shift,
    input  logic         do_xor,
    input  logic         do_add,
    output logic [W-1:0] a_out
);
    localparam int LINKS = W - 1;

    slice_ctl_t   ctl;
    logic [W-1:0] chain;

    op_decoder u_dec (
        .do_shift (do_shift),
        .do_xor   (do_xor),
        .do_add   (do_add),
        .ctl      (ctl)
    );

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        slice_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .b_bit   (b_in[i]),
            .ci      (chain[i]),
            .load    (ctl.load),
            .pick_ci (ctl.pick_ci),
            .a_bit   (a_out[i])
        );
        if (i < LINKS) begin : g_link
            carry_link u_link (
                .a_bit    (a_out[i]),
                .b_bit    (b_in[i]),
                .ci       (chain[i]),
                .pick_ci  (ctl.pick_ci),
                .carry_en (ctl.carry_en),
                .co       (chain[i+1])
            );
        end
    end
endmodule

// File: rtl/microop_reg_chk.sv
module microop_reg_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] b_in,
    input logic         do_shift,
    input logic         do_xor,
    input logic         do_add,
    input logic [W-1:0] a_out
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (a_out == '0));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!do_shift && !do_xor && !do_add) |=> $stable(a_out));

    // R3 and R6: shift wins over any other line
    a_r3_shift_left: assert property (@(posedge clk) disable iff (rst)
        do_shift |=> (a_out == {$past(a_out[W-2:0]), 1'b0}));

    // R4 and R6: add wins over xor
    a_r4_add_wraps: assert property (@(posedge clk) disable iff (rst)
        (do_add && !do_shift) |=> (a_out == W'($past(a_out) + $past(b_in))));

    a_r5_xor_only: assert property (@(posedge clk) disable iff (rst)
        (do_xor && !do_add && !do_shift) |=> (a_out == ($past(a_out) ^ $past(b_in))));

    a_r6_shift_beats_add: assert property (@(posedge clk) disable iff (rst)
        (do_shift && do_add) |=> (a_out[0] == 1'b0));
endmodule

bind microop_reg microop_reg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .b_in     (b_in),
    .do_shift (do_shift),
    .do_xor   (do_xor),
    .do_add   (do_add),
    .a_out    (a_out)
);

// File: tb/tb_microop_reg.sv
`timescale 1ns/1ps
module tb_microop_reg;
    localparam int W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] b_in = '0;
    logic         do_shift = 1'b0;
    logic         do_xor = 1'b0;
    logic         do_add = 1'b0;
    logic [W-1:0] a_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_a;

    always #5 clk = ~clk;

    microop_reg #(.W(W)) dut (
        .clk(clk), .rst(rst), .b_in(b_in),
        .do_shift(do_shift), .do_xor(do_xor), .do_add(do_add),
        .a_out(a_out)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                           logic s, logic x, logic ad);
        if (s)       return {a[W-2:0], 1'b0};
        else if (ad) return W'(a + b);
        else if (x)  return a ^ b;
        else         return a;
    endfunction

    function automatic string tag_of(logic s, logic x, logic ad);
        int n = int'(s) + int'(x) + int'(ad);
        if (n > 1)   return "R6";
        else if (s)  return "R3";
        else if (ad) return "R4";
        else if (x)  return "R5";
        else         return "R2";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: a_out=%h expected %h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge (R7).
    task automatic step(logic s, logic x, logic ad, logic [W-1:0] b);
        @(negedge clk);
        do_shift = s; do_xor = x; do_add = ad; b_in = b;
        exp_a = model(exp_a, b, s, x, ad);
        @(posedge clk);
        #1;
        check(tag_of(s, x, ad), a_out, exp_a);
    endtask

    task automatic load(logic [W-1:0] v);
        // clear then add v
        @(negedge clk); rst = 1'b1; do_shift = 0; do_xor = 0; do_add = 0;
        @(posedge clk); #1; exp_a = '0;
        @(negedge clk); rst = 1'b0;
        step(1'b0, 1'b0, 1'b1, v);
    endtask

    initial begin
        void'($urandom(32'd1234));
        exp_a = '0;
        // R1: reset with controls active still clears
        @(negedge clk); rst = 1'b1; do_add = 1'b1; b_in = 16'h5a5a;
        @(posedge clk); #1;
        check("R1", a_out, '0);
        @(negedge clk); rst = 1'b0; do_add = 1'b0;

        load(16'h1234);
        // R2: hold while b_in changes
        step(0, 0, 0, 16'hffff);
        step(0, 0, 0, 16'h0f0f);
        // R4: carry through every slice and out of the top
        load(16'h0001);
        step(0, 0, 1, ONES);
        load(ONES);
        step(0, 0, 1, ONES);
        // R3: top bit dropped, zero fill at bit 0
        load(16'h8001);
        step(1, 0, 0, ONES);
        step(1, 0, 0, 16'h0000);
        // R5: operands that would carry in an adder
        load(16'h00ff);
        step(0, 1, 0, 16'h00ff);
        step(0, 1, 0, 16'hffff);
        // R6: priority with several lines high
        load(16'hc003);
        step(1, 1, 1, 16'h0001);
        step(0, 1, 1, 16'h0101);
        step(1, 1, 0, 16'h0f00);
        // R1 again after activity
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; exp_a = '0;
        check("R1", a_out, '0);
        @(negedge clk); rst = 1'b0;

        // Random mix, mostly one-hot
        for (int k = 0; k < 3000; k++) begin
            int sel = int'($urandom_range(0, 9));
            logic s = (sel == 1) || (sel == 8);
            logic x = (sel == 2) || (sel == 3) || (sel == 9);
            logic ad = (sel == 4) || (sel == 5) || (sel == 8) || (sel == 9);
            step(s, x, ad, W'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule